// File: doc/BRIEF.md
# Flat-Panel Power Sequencer

This block switches the four enables of a flat-panel display in a fixed order: panel supply, the LVDS data link, the PWM dimming output and the backlight. Each step of power-up and of power-down is separated by a programmable delay. A further programmable minimum-off gap must elapse after the supply goes low before a new cycle may start. A level request input (`panelOn`) selects the target: on or off.

Seven 8-bit delay counts are loaded through an index/data write port. Some delays count whole milliseconds and others count 4 ms units. The millisecond time base comes from a free-running prescaler set by the `CLK_PER_MS` parameter. `busy` and a state code report progress.

Top module: `pnl_pwr_seq`

## Requirements
- R1: After reset all four enables are low, `busy` is low, `seqState` reads 0 (idle-off), every delay count is zero and the off-gap counts as already elapsed.
- R2: On a rising request the enables rise in the order supply, link, PWM, backlight. Supply to link takes the index 0x32 count in 1 ms units. Link to PWM takes the index 0x33 count in 4 ms units. PWM to backlight takes the index 0x34 count in 1 ms units. One unit of 1 ms is `CLK_PER_MS` clock cycles.
- R3: On a falling request the enables fall in the order backlight, PWM, link, supply. Backlight to PWM takes the index 0x35 count in 1 ms units. PWM to link takes the index 0x36 count in 4 ms units. Link to supply takes the index 0x37 count in 1 ms units.
- R4: Writes with `regWrEn` high to indexes 0x32 to 0x38 load the seven counts. Writes to any other index change no delay.
- R5: A delay count of zero lets the next enable change happen one clock cycle after the previous one.
- R6: When the supply falls, a gap of the index 0x38 count in 4 ms units starts and `busy` stays high through it. A request raised during the gap is held, and the supply rises again one cycle after the gap ends.
- R7: If the request drops during power-up, the running delay completes. Power-down then starts by turning off the highest enable that is on, and no further enable rises.
- R8: A running delay keeps the count it captured when it began, even if its register is rewritten meanwhile.
- R9: `busy` is low only when all enables are off with the gap elapsed (`seqState` 0) or all enables are on (`seqState` 4). `seqState` reads 2 while waiting to raise PWM and 8 during the gap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| panelOn | input | 1 | Level request: 1 = panel on, 0 = panel off |
| regWrEn | input | 1 | Delay register write strobe |
| regIdx | input | IDX_W | Delay register index (0x32 to 0x38) |
| regData | input | DLY_W | Delay count to write |
| supplyEn | output | 1 | Panel supply enable |
| linkEn | output | 1 | LVDS data output enable |
| pwmEn | output | 1 | PWM output enable |
| blEn | output | 1 | Backlight enable |
| busy | output | 1 | Sequence or gap in progress |
| seqState | output | 4 | Sequencer state code |

## Verification
The full up and down runs use distinct counts per step. A swapped register index or a swapped unit size therefore shows up as a wrong interval. Dropping the request while waiting for the link and while waiting for PWM separates the two skip paths into power-down. A request raised right after the supply falls shows whether the gap holds it back. All-zero counts expose the one-cycle step. Rewriting the running delay's register mid-wait tells a captured count from a live one.

// File: rtl/pnl_seq_pkg.sv
package pnl_seq_pkg;

  localparam int NUM_DLY = 7;
  localparam int SEL_W   = 3;

  // Delay slots counted in 4 ms units: link->PWM (1), PWM->link (4), gap (6)
  localparam logic [7:0] QUAD_MASK = 8'b0101_0010;

  typedef enum logic [3:0] {
    ST_OFF = 4'd0,
    ST_UP1 = 4'd1,
    ST_UP2 = 4'd2,
    ST_UP3 = 4'd3,
    ST_ON  = 4'd4,
    ST_DN4 = 4'd5,
    ST_DN5 = 4'd6,
    ST_DN6 = 4'd7,
    ST_GAP = 4'd8
  } seq_state_e;

  typedef struct packed {
    logic             load;
    logic [SEL_W-1:0] sel;
  } dly_cmd_t;

endpackage

// File: rtl/pnl_ms_tick.sv
module pnl_ms_tick #(
  parameter int CLK_PER_MS = 200000
) (
  input  logic clk,
  input  logic rstN,
  output logic msTick
);

  generate
    if (CLK_PER_MS <= 1) begin : g_pass
      assign msTick = rstN;
    end else begin : g_div
      localparam int PW = $clog2(CLK_PER_MS);
      localparam logic [PW-1:0] LAST = PW'(CLK_PER_MS - 1);
      logic [PW-1:0] preCnt;

      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) begin
          preCnt <= '0;
        end else if (preCnt == LAST) begin
          preCnt <= '0;
        end else begin
          preCnt <= preCnt + 1'b1;
        end
      end

      assign msTick = (preCnt == LAST);
    end
  endgenerate

endmodule

// File: rtl/pnl_seq_dp.sv
module pnl_seq_dp
  import pnl_seq_pkg::*;
#(
  parameter int CLK_PER_MS = 200000,
  parameter int DLY_W      = 8,
  parameter int IDX_W      = 8,
  parameter int REG_BASE   = 8'h32
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             regWrEn,
  input  logic [IDX_W-1:0] regIdx,
  input  logic [DLY_W-1:0] regData,
  input  dly_cmd_t         cmd,
  output logic             dlyDone
);

  logic             msTick;
  logic [DLY_W-1:0] dlyReg [NUM_DLY];
  logic [DLY_W-1:0] remain;
  logic [1:0]       quarter;
  logic             quadMode;
  logic [DLY_W-1:0] pickCnt;
  logic             pickQuad;

  pnl_ms_tick #(.CLK_PER_MS(CLK_PER_MS)) u_tick (
    .clk    (clk),
    .rstN   (rstN),
    .msTick (msTick)
  );

  // Delay count registers at consecutive indexes
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < NUM_DLY; i++) dlyReg[i] <= '0;
    end else if (regWrEn) begin
      for (int i = 0; i < NUM_DLY; i++) begin
        if (regIdx == IDX_W'(REG_BASE + i)) dlyReg[i] <= regData;
      end
    end
  end

  always_comb begin
    pickCnt  = '0;
    pickQuad = 1'b0;
    for (int i = 0; i < NUM_DLY; i++) begin
      if (cmd.sel == SEL_W'(i)) begin
        pickCnt  = dlyReg[i];
        pickQuad = QUAD_MASK[i];
      end
    end
  end

  // Running delay: captures its count at load, then counts ms ticks
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      remain   <= '0;
      quarter  <= '0;
      quadMode <= 1'b0;
    end else if (cmd.load) begin
      remain   <= pickCnt;
      quarter  <= '0;
      quadMode <= pickQuad;
    end else if (msTick && (remain != '0)) begin
      if (!quadMode || (quarter == 2'd3)) begin
        remain  <= remain - 1'b1;
        quarter <= '0;
      end else begin
        quarter <= quarter + 1'b1;
      end
    end
  end

  assign dlyDone = (remain == '0);

endmodule

// File: rtl/pnl_seq_ctrl.sv
module pnl_seq_ctrl
  import pnl_seq_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       panelOn,
  input  logic       dlyDone,
  output seq_state_e state,
  output dly_cmd_t   cmd
);

  seq_state_e nxt;

  always_comb begin
    nxt = state;
    unique case (state)
      ST_OFF: if (panelOn) nxt = ST_UP1;
      ST_UP1: if (dlyDone) nxt = panelOn ? ST_UP2 : ST_GAP;
      ST_UP2: if (dlyDone) nxt = panelOn ? ST_UP3 : ST_DN6;
      ST_UP3: if (dlyDone) nxt = panelOn ? ST_ON  : ST_DN5;
      ST_ON:  if (!panelOn) nxt = ST_DN4;
      ST_DN4: if (dlyDone) nxt = ST_DN5;
      ST_DN5: if (dlyDone) nxt = ST_DN6;
      ST_DN6: if (dlyDone) nxt = ST_GAP;
      ST_GAP: if (dlyDone) nxt = ST_OFF;
      default: nxt = ST_OFF;
    endcase
  end

  // Start the delay that belongs to the state being entered
  always_comb begin
    cmd.load = (nxt != state) && (nxt != ST_OFF) && (nxt != ST_ON);
    unique case (nxt)
      ST_UP1:  cmd.sel = 3'd0;
      ST_UP2:  cmd.sel = 3'd1;
      ST_UP3:  cmd.sel = 3'd2;
      ST_DN4:  cmd.sel = 3'd3;
      ST_DN5:  cmd.sel = 3'd4;
      ST_DN6:  cmd.sel = 3'd5;
      ST_GAP:  cmd.sel = 3'd6;
      default: cmd.sel = 3'd0;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= ST_OFF;
    else       state <= nxt;
  end

endmodule

// File: rtl/pnl_pwr_seq.sv
module pnl_pwr_seq
  import pnl_seq_pkg::*;
#(
  parameter int CLK_PER_MS = 200000,
  parameter int DLY_W      = 8,
  parameter int IDX_W      = 8,
  parameter int REG_BASE   = 8'h32
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             panelOn,
  input  logic             regWrEn,
  input  logic [IDX_W-1:0] regIdx,
  input  logic [DLY_W-1:0] regData,
  output logic             supplyEn,
  output logic             linkEn,
  output logic             pwmEn,
  output logic             blEn,
  output logic             busy,
  output logic [3:0]       seqState
);

  seq_state_e state;
  dly_cmd_t   cmd;
  logic       dlyDone;

  pnl_seq_ctrl u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .panelOn (panelOn),
    .dlyDone (dlyDone),
    .state   (state),
    .cmd     (cmd)
  );

  pnl_seq_dp #(
    .CLK_PER_MS (CLK_PER_MS),
    .DLY_W      (DLY_W),
    .IDX_W      (IDX_W),
    .REG_BASE   (REG_BASE)
  ) u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .regWrEn (regWrEn),
    .regIdx  (regIdx),
    .regData (regData),
    .cmd     (cmd),
    .dlyDone (dlyDone)
  );

  assign supplyEn = (state inside {ST_UP1, ST_UP2, ST_UP3, ST_ON, ST_DN4, ST_DN5, ST_DN6});
  assign linkEn   = (state inside {ST_UP2, ST_UP3, ST_ON, ST_DN4, ST_DN5});
  assign pwmEn    = (state inside {ST_UP3, ST_ON, ST_DN4});
  assign blEn     = (state == ST_ON);
  assign busy     = (state != ST_OFF) && (state != ST_ON);
  assign seqState = state;

endmodule

// File: rtl/pnl_seq_chk.sv
module pnl_seq_chk (
  input logic clk,
  input logic rstN,
  input logic panelOn,
  input logic supplyEn,
  input logic linkEn,
  input logic pwmEn,
  input logic blEn,
  input logic busy
);

  a_r2_link_after_supply: assert property (@(posedge clk) disable iff (!rstN)
    $rose(linkEn) |-> supplyEn);
  a_r2_pwm_after_link: assert property (@(posedge clk) disable iff (!rstN)
    $rose(pwmEn) |-> linkEn);
  a_r2_bl_after_pwm: assert property (@(posedge clk) disable iff (!rstN)
    $rose(blEn) |-> pwmEn);
  a_r2_one_step: assert property (@(posedge clk) disable iff (!rstN)
    $countones({supplyEn ^ $past(supplyEn), linkEn ^ $past(linkEn),
                pwmEn ^ $past(pwmEn), blEn ^ $past(blEn)}) <= 1);
  a_r3_pwm_off_after_bl: assert property (@(posedge clk) disable iff (!rstN)
    $fell(pwmEn) |-> !blEn);
  a_r3_link_off_after_pwm: assert property (@(posedge clk) disable iff (!rstN)
    $fell(linkEn) |-> !pwmEn);
  a_r3_supply_off_after_link: assert property (@(posedge clk) disable iff (!rstN)
    $fell(supplyEn) |-> !linkEn);
  a_r6_gap_busy: assert property (@(posedge clk) disable iff (!rstN)
    $fell(supplyEn) |-> busy);
  a_r6_rise_needs_request: assert property (@(posedge clk) disable iff (!rstN)
    $rose(supplyEn) |-> $past(panelOn));
  a_r7_no_rise_when_dropped: assert property (@(posedge clk) disable iff (!rstN)
    ($rose(linkEn) || $rose(pwmEn) || $rose(blEn)) |-> $past(panelOn));
  a_r9_idle_consistent: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> ((supplyEn && linkEn && pwmEn && blEn) ||
               (!supplyEn && !linkEn && !pwmEn && !blEn)));

endmodule

bind pnl_pwr_seq pnl_seq_chk u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .panelOn  (panelOn),
  .supplyEn (supplyEn),
  .linkEn   (linkEn),
  .pwmEn    (pwmEn),
  .blEn     (blEn),
  .busy     (busy)
);

// File: tb/pnl_pwr_seq_test.sv
`timescale 1ns/1ps
module pnl_pwr_seq_test;

  localparam int C = 10;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       panelOn = 1'b0;
  logic       regWrEn = 1'b0;
  logic [7:0] regIdx = '0;
  logic [7:0] regData = '0;
  logic       supplyEn, linkEn, pwmEn, blEn, busy;
  logic [3:0] seqState;

  int total = 0;
  int bad = 0;
  int cyc = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  pnl_pwr_seq #(.CLK_PER_MS(C)) uut (
    .clk(clk), .rstN(rstN), .panelOn(panelOn), .regWrEn(regWrEn),
    .regIdx(regIdx), .regData(regData), .supplyEn(supplyEn), .linkEn(linkEn),
    .pwmEn(pwmEn), .blEn(blEn), .busy(busy), .seqState(seqState)
  );

  // Index: 0 supply, 1 link, 2 pwm, 3 backlight, 4 busy
  logic [4:0] curV;
  logic [4:0] prevV = '0;
  int riseAt [5];
  int fallAt [5];
  int riseCnt [5];
  assign curV = {busy, blEn, pwmEn, linkEn, supplyEn};

  always @(posedge clk) cyc <= cyc + 1;

  always @(negedge clk) begin
    for (int i = 0; i < 5; i++) begin
      if (curV[i] && !prevV[i]) begin
        riseAt[i] = cyc;
        riseCnt[i] = riseCnt[i] + 1;
      end else if (!curV[i] && prevV[i]) begin
        fallAt[i] = cyc;
      end
    end
    prevV = curV;
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // Interval of u time units: window allows for the free-running first tick
  task automatic chkWin(input string req, input string what, input int act,
                        input int u, input int extra);
    int lo, hi;
    if (u == 0) begin
      lo = 1 + extra;
      hi = 1 + extra;
    end else begin
      lo = (u - 1) * C + 1;
      hi = u * C + 2 + extra;
    end
    chk(act >= lo && act <= hi, req, what, act, u * C + 1 + extra);
  endtask

  task automatic wrReg(input logic [7:0] idx, input logic [7:0] val);
    @(negedge clk);
    regWrEn = 1'b1;
    regIdx  = idx;
    regData = val;
    @(negedge clk);
    regWrEn = 1'b0;
  endtask

  task automatic waitFor(input int idx, input bit val, input string req);
    int n = 0;
    @(negedge clk); #1;
    while (curV[idx] !== val && n < 20000) begin
      @(negedge clk); #1;
      n++;
    end
    if (curV[idx] !== val) chk(1'b0, req, "timeout waiting for signal", idx, 32'(val));
  endtask

  task automatic setTimes(input int a, input int b, input int c3, input int d,
                          input int e, input int f, input int g);
    wrReg(8'h32, 8'(a)); wrReg(8'h33, 8'(b)); wrReg(8'h34, 8'(c3));
    wrReg(8'h35, 8'(d)); wrReg(8'h36, 8'(e)); wrReg(8'h37, 8'(f));
    wrReg(8'h38, 8'(g));
  endtask

  task automatic goIdle();
    panelOn = 1'b0;
    waitFor(4, 1'b0, "R9");
  endtask

  task automatic testReset();
    @(negedge clk); #1;
    chk({supplyEn, linkEn, pwmEn, blEn} == 4'b0, "R1", "enables after reset",
        {supplyEn, linkEn, pwmEn, blEn}, 0);
    chk(busy == 1'b0, "R1", "busy after reset", busy, 0);
    chk(seqState == 4'd0, "R1", "state after reset", seqState, 0);
  endtask

  task automatic testPowerUp();
    // Off-map writes that would break every interval if decoded (R4)
    wrReg(8'h31, 8'hFF);
    wrReg(8'h39, 8'hFF);
    panelOn = 1'b1;
    waitFor(1, 1'b1, "R2");
    chk(busy == 1'b1 && seqState == 4'd2, "R9", "busy/state waiting for pwm",
        {busy, seqState}, 5'h12);
    waitFor(3, 1'b1, "R2");
    chkWin("R2", "supply->link (T1=3ms)", riseAt[1] - riseAt[0], 3, 0);
    chkWin("R2", "link->pwm (T2=2x4ms)", riseAt[2] - riseAt[1], 8, 0);
    chkWin("R2", "pwm->backlight (T3=5ms)", riseAt[3] - riseAt[2], 5, 0);
    @(negedge clk); #1;
    chk(busy == 1'b0 && seqState == 4'd4, "R9", "idle when fully on",
        {busy, seqState}, 5'h04);
  endtask

  task automatic testPowerDown();
    panelOn = 1'b0;
    waitFor(0, 1'b0, "R3");
    chkWin("R3", "backlight->pwm off (T4=1ms)", fallAt[2] - fallAt[3], 1, 0);
    chkWin("R3", "pwm->link off (T5=1x4ms)", fallAt[1] - fallAt[2], 4, 0);
    chkWin("R3", "link->supply off (T6=2ms)", fallAt[0] - fallAt[1], 2, 0);
    chk(busy == 1'b1 && seqState == 4'd8, "R6", "busy/state in gap",
        {busy, seqState}, 5'h18);
    waitFor(4, 1'b0, "R6");
    chkWin("R6", "gap length (T7=3x4ms), R4 idx 0x39 ignored",
           fallAt[4] - fallAt[0], 12, 0);
    chk(seqState == 4'd0, "R9", "state after gap", seqState, 0);
  endtask

  task automatic testGapPending();
    panelOn = 1'b1;
    waitFor(3, 1'b1, "R6");
    panelOn = 1'b0;
    waitFor(0, 1'b0, "R6");
    panelOn = 1'b1;
    repeat (C) @(negedge clk);
    #1;
    chk(supplyEn == 1'b0, "R6", "request held during gap", supplyEn, 0);
    waitFor(0, 1'b1, "R6");
    chkWin("R6", "supply off->on across gap", riseAt[0] - fallAt[0], 12, 1);
    waitFor(3, 1'b1, "R6");
    goIdle();
  endtask

  task automatic testZero();
    setTimes(0, 0, 0, 0, 0, 0, 0);
    panelOn = 1'b1;
    waitFor(3, 1'b1, "R5");
    chkWin("R5", "zero T1 step", riseAt[1] - riseAt[0], 0, 0);
    chkWin("R5", "zero T2 step", riseAt[2] - riseAt[1], 0, 0);
    chkWin("R5", "zero T3 step", riseAt[3] - riseAt[2], 0, 0);
    goIdle();
    chkWin("R5", "zero T6 step", fallAt[0] - fallAt[1], 0, 0);
    setTimes(3, 2, 5, 1, 1, 2, 3);
  endtask

  task automatic testWithdrawInT2();
    int pwmRises = riseCnt[2];
    panelOn = 1'b1;
    waitFor(1, 1'b1, "R7");
    panelOn = 1'b0;
    waitFor(0, 1'b0, "R7");
    chk(riseCnt[2] == pwmRises, "R7", "pwm never raised", riseCnt[2], pwmRises);
    chkWin("R7", "link kept for full T2", fallAt[1] - riseAt[1], 8, 0);
    chkWin("R7", "link->supply off T6", fallAt[0] - fallAt[1], 2, 0);
    waitFor(4, 1'b0, "R7");
  endtask

  task automatic testWithdrawInT1();
    int linkRises = riseCnt[1];
    panelOn = 1'b1;
    waitFor(0, 1'b1, "R7");
    panelOn = 1'b0;
    waitFor(0, 1'b0, "R7");
    chk(riseCnt[1] == linkRises, "R7", "link never raised", riseCnt[1], linkRises);
    chkWin("R7", "supply kept for full T1", fallAt[0] - riseAt[0], 3, 0);
    waitFor(4, 1'b0, "R7");
  endtask

  task automatic testLatched();
    panelOn = 1'b1;
    waitFor(1, 1'b1, "R8");
    wrReg(8'h33, 8'hFF);
    waitFor(2, 1'b1, "R8");
    chkWin("R8", "running T2 keeps captured count", riseAt[2] - riseAt[1], 8, 0);
    wrReg(8'h33, 8'd2);
    waitFor(3, 1'b1, "R8");
    goIdle();
  endtask

  task automatic finish();
    if (!finished) begin
      finished = 1'b1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  initial begin
    for (int i = 0; i < 5; i++) begin
      riseAt[i] = 0; fallAt[i] = 0; riseCnt[i] = 0;
    end
    repeat (4) @(posedge clk);
    testReset();
    @(negedge clk);
    rstN = 1'b1;
    setTimes(3, 2, 5, 1, 1, 2, 3);
    testPowerUp();
    testPowerDown();
    testGapPending();
    testZero();
    testWithdrawInT2();
    testWithdrawInT1();
    testLatched();
    finish();
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog: actual=hung expected=complete");
      finish();
    end
  end

endmodule